// File: doc/BRIEF.md
# NAK Retry Counter Unit

This unit throttles retries on one queue head of a USB host schedule engine. When the engine fetches a queue head, it presents the queue head's 4-bit reload value and pulses a load strobe. The unit then keeps a running count of how many NAK handshakes the endpoint may still return before the engine stops issuing transactions to it.

At the end of each transaction the engine pulses a completion strobe, together with a flag that says whether the transaction ended in NAK.
- A NAK lowers the count by one, stopping at zero.
- Any other outcome refills the count from the reload value.
- Once the count reaches zero while the reload value is nonzero, the unit raises a skip indication. The engine then moves on to the next queue head instead of executing.
- A reload value of zero turns the whole mechanism off.

The engine writes the count back into the queue head; that step is not part of this unit.

Top module: `nak_throttle`

## Requirements
- R1: After reset, `count_o` is zero and `skip_o` is low.
- R2: With `reload_i` zero, `skip_o` stays low whatever the count is, and a load strobe leaves the count unchanged.
- R3: A load strobe without a completion strobe, with `reload_i` nonzero, makes `count_o` equal `reload_i` one clock later.
- R4: A completion with NAK, with `reload_i` nonzero and the count above zero, lowers `count_o` by exactly one on the next clock.
- R5: A completion with NAK while the count is zero leaves the count at zero; it never wraps to the all-ones value.
- R6: A completion without NAK makes `count_o` equal `reload_i` on the next clock, including the value zero.
- R7: `skip_o` is high in the same cycle exactly when `reload_i` is nonzero and `count_o` is zero, without a clock of delay.
- R8: When the load and completion strobes are high in the same cycle, the completion update is applied and the load is ignored.
- R9: A completion with NAK while `reload_i` is zero leaves the count unchanged.
- R10: With neither strobe high, the count holds its value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| reload_i | input | CNT_W (4) | Reload value from the endpoint characteristics; zero disables throttling |
| qh_load_i | input | 1 | Pulses when a queue head is fetched |
| done_i | input | 1 | Pulses when a transaction completes |
| done_nak_i | input | 1 | Qualifies `done_i`: the transaction ended in NAK |
| count_o | output | CNT_W (4) | Current NAK count |
| skip_o | output | 1 | Tells the engine not to execute and to move horizontally |

## Verification
The bench builds the unit with the default 4-bit count. At that width the full range of the field can be reached: the largest reload value of 15 can be counted down step by step to the zero floor. The same width also reaches the case where a decrement at zero would wrap to all ones if saturation were missing. The bench drives reload values of zero, one, mid-range and the maximum, so the disabled path and every priority between the two strobes get exercised.

// File: rtl/nak_throttle_pkg.sv
package nak_throttle_pkg;

   // Kind of update applied to the NAK counter in a given cycle.
   typedef enum logic [1:0] {
      UPD_HOLD   = 2'd0,
      UPD_LOAD   = 2'd1,
      UPD_DEC    = 2'd2,
      UPD_REFILL = 2'd3
   } upd_kind_e;

endpackage

// File: rtl/nak_upd_sel.sv
// Chooses the counter update for this cycle; completion outranks load.
module nak_upd_sel
   import nak_throttle_pkg::*;
(
   input  logic      load_i,
   input  logic      done_i,
   input  logic      nak_i,
   input  logic      reload_nz_i,
   output upd_kind_e kind_o
);

   always_comb begin
      kind_o = UPD_HOLD;
      if (done_i) begin
         if (!nak_i)
            kind_o = UPD_REFILL;
         else if (reload_nz_i)
            kind_o = UPD_DEC;
         else
            kind_o = UPD_HOLD;
      end else if (load_i && reload_nz_i) begin
         kind_o = UPD_LOAD;
      end
   end

endmodule

// File: rtl/nak_cnt_path.sv
// Next-count datapath: load/refill, saturating decrement, or hold.
module nak_cnt_path
   import nak_throttle_pkg::*;
#(
   parameter int CNT_W = 4
) (
   input  upd_kind_e        kind_i,
   input  logic [CNT_W-1:0] reload_i,
   input  logic [CNT_W-1:0] cnt_i,
   output logic [CNT_W-1:0] cnt_nxt_o
);

   localparam logic [CNT_W-1:0] ZERO = '0;
   localparam logic [CNT_W-1:0] ONE  = {{(CNT_W-1){1'b0}}, 1'b1};

   logic [CNT_W-1:0] dec_val;

   assign dec_val = (cnt_i == ZERO) ? ZERO : cnt_i - ONE;

   always_comb begin
      case (kind_i)
         UPD_LOAD,
         UPD_REFILL: cnt_nxt_o = reload_i;
         UPD_DEC:    cnt_nxt_o = dec_val;
         default:    cnt_nxt_o = cnt_i;
      endcase
   end

endmodule

// File: rtl/nak_cnt_reg.sv
// State register for the NAK count.
module nak_cnt_reg #(
   parameter int CNT_W = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [CNT_W-1:0] d_i,
   output logic [CNT_W-1:0] q_o
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         q_o <= '0;
      else
         q_o <= d_i;
   end

endmodule

// File: rtl/nak_throttle.sv
module nak_throttle
   import nak_throttle_pkg::*;
#(
   parameter int CNT_W = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [CNT_W-1:0] reload_i,
   input  logic             qh_load_i,
   input  logic             done_i,
   input  logic             done_nak_i,
   output logic [CNT_W-1:0] count_o,
   output logic             skip_o
);

   localparam logic [CNT_W-1:0] ZERO = '0;
   localparam logic [CNT_W-1:0] ONE  = {{(CNT_W-1){1'b0}}, 1'b1};

   generate
      if (CNT_W < 1 || CNT_W > 16) begin : g_bad_width
         $error("nak_throttle: CNT_W must lie in 1..16");
      end
   endgenerate

   logic             reload_nz;
   upd_kind_e        kind;
   logic [CNT_W-1:0] cnt_q;
   logic [CNT_W-1:0] cnt_d;

   assign reload_nz = (reload_i != ZERO);

   nak_upd_sel u_sel (
      .load_i      (qh_load_i),
      .done_i      (done_i),
      .nak_i       (done_nak_i),
      .reload_nz_i (reload_nz),
      .kind_o      (kind)
   );

   nak_cnt_path #(.CNT_W(CNT_W)) u_path (
      .kind_i    (kind),
      .reload_i  (reload_i),
      .cnt_i     (cnt_q),
      .cnt_nxt_o (cnt_d)
   );

   nak_cnt_reg #(.CNT_W(CNT_W)) u_reg (
      .clk   (clk),
      .rst_n (rst_n),
      .d_i   (cnt_d),
      .q_o   (cnt_q)
   );

   assign count_o = cnt_q;
   assign skip_o  = reload_nz && (cnt_q == ZERO);

   AST_LOAD_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
      (qh_load_i && !done_i && reload_i != ZERO) |=> count_o == $past(reload_i)); // R3
   AST_NAK_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      (done_i && done_nak_i && reload_i != ZERO && count_o != ZERO) |=> count_o == $past(count_o) - ONE); // R4
   AST_NO_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
      (done_i && done_nak_i && count_o == ZERO) |=> count_o == ZERO); // R5
   AST_OK_REFILL: assert property (@(posedge clk) disable iff (!rst_n)
      (done_i && !done_nak_i) |=> count_o == $past(reload_i)); // R6
   AST_OFF_NO_SKIP: assert property (@(posedge clk) disable iff (!rst_n)
      (reload_i == ZERO) |-> !skip_o); // R2
   AST_OFF_NAK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (done_i && done_nak_i && reload_i == ZERO) |=> $stable(count_o)); // R9
   AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (!done_i && !qh_load_i) |=> $stable(count_o)); // R10

endmodule

// File: tb/nak_throttle_tb_top.sv
`timescale 1ns/1ps
module nak_throttle_tb_top;

   localparam int W = 4;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic [W-1:0] reload = '0;
   logic         ld = 1'b0, dn = 1'b0, nk = 1'b0;
   logic [W-1:0] count;
   logic         skip;

   int checks = 0;
   int errors = 0;
   bit finished = 1'b0;

   logic [W-1:0] exp_q[$];
   string        tag_q[$];
   logic [W-1:0] mcount = '0;

   always #2.5 clk = ~clk;

   nak_throttle #(.CNT_W(W)) dut_i (
      .clk(clk), .rst_n(rst_n), .reload_i(reload), .qh_load_i(ld),
      .done_i(dn), .done_nak_i(nk), .count_o(count), .skip_o(skip));

   task automatic check(input string tag, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   // Driver: applies one cycle of stimulus, checks skip in-cycle (R7),
   // and pushes the count expected after the next rising edge.
   task automatic step(input logic l, input logic d, input logic n,
                       input logic [W-1:0] r, input string tag);
      logic [W-1:0] nxt;
      @(negedge clk);
      ld = l; dn = d; nk = n; reload = r;
      #0.5;
      check({"R7 skip ", tag}, int'(skip), int'(r != 0 && mcount == 0));
      nxt = mcount;
      if (d) begin
         if (!n) nxt = r;                                   // R6
         else if (r != 0) nxt = (mcount == 0) ? 4'd0 : mcount - 4'd1; // R4 R5
      end else if (l && r != 0) begin
         nxt = r;                                           // R3
      end
      mcount = nxt;
      exp_q.push_back(nxt);
      tag_q.push_back(tag);
   endtask

   // Monitor: pops and compares after each rising edge.
   initial begin
      forever begin
         @(posedge clk);
         #1;
         if (exp_q.size() > 0) begin
            logic [W-1:0] e;
            string t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            check(t, int'(count), int'(e));
         end
      end
   end

   initial begin
      repeat (2000) @(posedge clk);
      if (!finished) begin
         errors++;
         checks++;
         $display("FAIL watchdog expired");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      repeat (3) @(posedge clk);
      #1;
      check("R1 count after reset", int'(count), 0);
      check("R1 skip after reset", int'(skip), 0);
      @(negedge clk);
      rst_n = 1'b1;

      step(1, 0, 0, 4'd0, "R2 load with reload zero");
      step(0, 0, 0, 4'd0, "R2 idle reload zero");
      step(1, 0, 0, 4'd5, "R3 load 5");
      step(0, 0, 0, 4'd5, "R10 idle hold");
      for (int i = 0; i < 5; i++) step(0, 1, 1, 4'd5, "R4 nak decrement");
      step(0, 0, 0, 4'd5, "R7 skip at zero");
      step(0, 1, 1, 4'd5, "R5 nak at zero floor");
      step(0, 1, 1, 4'd5, "R5 nak at zero again");
      step(0, 1, 0, 4'd5, "R6 ok refill 5");
      step(1, 1, 1, 4'd3, "R8 done nak beats load");
      step(1, 1, 0, 4'd2, "R8 done ok beats load");
      step(0, 1, 1, 4'd0, "R9 nak with reload zero");
      step(0, 0, 0, 4'd0, "R2 no skip when disabled");
      step(0, 1, 0, 4'd0, "R6 ok refill zero");
      step(0, 0, 0, 4'd0, "R2 zero count disabled");
      step(1, 0, 0, 4'd15, "R3 load max");
      for (int i = 0; i < 16; i++) step(0, 1, 1, 4'd15, "R4 R5 drain max");
      step(1, 0, 0, 4'd1, "R3 load 1");
      step(0, 1, 1, 4'd1, "R4 nak to zero");
      step(1, 0, 0, 4'd1, "R3 reload after skip");
      step(0, 0, 0, 4'd1, "R10 idle hold 1");
      step(0, 0, 0, 4'd0, "R2 idle disabled");
      repeat (3) @(posedge clk);
      #1;
      finished = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule